// File: doc/BRIEF.md
# Dual-Clock Rewindable Queue

This block is a first-in/first-out queue for 18-bit words whose producer and consumer run on unrelated clocks. Words enter on the write clock and leave on the read clock. Both enables are active low. Write and read pointers cross between the domains as Gray codes through two-flop synchronizers. Fullness and almost-full are judged on the write side, and emptiness and almost-empty on the read side. A half-full flag is also driven.

The read timing is chosen while master reset is held. In standard timing, each word is handed out only when a read is requested. In fall-through timing, the oldest word is moved to the output by itself and held there until a read consumes it. In fall-through timing the two status pins change meaning: they report input-ready and output-ready, both active low.

A partial reset clears both pointers and keeps the chosen timing. A master reset also takes the timing afresh. A rewind input sends the read pointer back to memory location zero, so a block of words written since reset can be handed out again. The almost-full and almost-empty thresholds arrive as plain inputs. An output-enable input forces the data output to zero while it is high.

Top module: `xclk_rewind_fifo`

## Requirements
- R1: A word on `din` is stored on a rising `wclk` edge when `wr_n` is 0 and the queue is not full. Words leave in the order they were stored.
- R2: A write attempted while full is dropped. The write pointer does not move and the stored words are unchanged. In standard timing the capacity is DEPTH words. In fall-through timing it is DEPTH+1, because the word held on the output no longer takes a memory slot. `full_ir_n` is 0 when full in standard timing and 1 when full in fall-through timing.
- R3: In standard timing, a read attempted while empty (`empty_or_n` = 0) leaves `dout` and the read pointer unchanged.
- R4: In standard timing, a rising `rclk` edge with `rd_n` = 0 and data present puts the oldest word on `dout`. The word stays there until the next such read.
- R5: In fall-through timing, a stored word reaches `dout` with no read request within 5 `rclk` edges of its write, and `empty_or_n` then goes to 0. An edge with `rd_n` = 0 consumes that word. When nothing remains, `empty_or_n` returns to 1.
- R6: `fwft_sel` is sampled only while `mrst_n` is 0 (1 = fall-through, 0 = standard). A partial reset keeps the timing, and later changes on `fwft_sel` have no effect.
- R7: While either reset is low, and right after it is released, the queue is empty and `dout` is 0. In standard timing `full_ir_n`=1, `empty_or_n`=0, `afull_n`=1, `aempty_n`=0 and `half_n`=1. In fall-through timing `full_ir_n`=0 and `empty_or_n`=1.
- R8: `half_n` is 0 while the write-side level exceeds DEPTH/2.
- R9: `afull_n` is 0 while DEPTH minus the write-side level is at most `af_ofs`. `af_ofs` must be below DEPTH.
- R10: `aempty_n` is 0 while the read-side level is at most `ae_ofs`.
- R11: `retx_n` = 0 on a rising `rclk` edge sets the read pointer to location 0 and takes priority over a read on that edge. In fall-through timing, word 0 is then presented again. A rewind is meaningful only while at most DEPTH words have been written since reset.
- R12: `oe_n` = 1 forces `dout` to 0 without disturbing the queue. Setting it back to 0 shows the held word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, clears pointers and resamples timing |
| prst_n | input | 1 | Partial reset, active low, clears pointers only |
| fwft_sel | input | 1 | Timing choice sampled during master reset, 1 = fall-through |
| wr_n | input | 1 | Write enable, active low |
| din | input | W | Write data |
| rd_n | input | 1 | Read enable, active low |
| retx_n | input | 1 | Rewind read pointer to location 0, active low |
| oe_n | input | 1 | Output enable, active low; high forces dout to 0 |
| af_ofs | input | AW+1 | Almost-full threshold in free words |
| ae_ofs | input | AW+1 | Almost-empty threshold in stored words |
| dout | output | W | Read data |
| full_ir_n | output | 1 | Full (standard, low = full) or input-ready (fall-through, low = ready) |
| empty_or_n | output | 1 | Empty (standard, low = empty) or output-ready (fall-through, low = word valid) |
| half_n | output | 1 | Half-full, active low |
| afull_n | output | 1 | Almost-full, active low |
| aempty_n | output | 1 | Almost-empty, active low |

## Verification
Some rules are checked on every clock edge. Pointers must advance by exactly one per accepted write. The write-side level may never pass DEPTH. A write while full or a read while empty must leave its pointer still. An idle fall-through output must load once data is visible, a rewind must leave the read pointer at zero, and the sampled timing must not change outside master reset. Other behaviour needs the bench's scenarios to show it at the ports: word order, the exact flag thresholds at each fill level, the capacity in each timing, what a rewind replays, the output gating, and a partial reset keeping the timing while `fwft_sel` is toggled.

// File: rtl/xclk_rewind_fifo.sv
module xclk_rewind_fifo #(
  parameter  int W     = 18,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic          wr_n,
  input  logic [W-1:0]  din,
  input  logic          rd_n,
  input  logic          retx_n,
  input  logic          oe_n,
  input  logic [PW-1:0] af_ofs,
  input  logic [PW-1:0] ae_ofs,
  output logic [W-1:0]  dout,
  output logic          full_ir_n,
  output logic          empty_or_n,
  output logic          half_n,
  output logic          afull_n,
  output logic          aempty_n
);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          arst_n;
  logic          fwft_w, fwft_r;
  logic [W-1:0]  mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rq1, rq2, rsync, wlevel;
  logic          full, wr_ok;

  logic [PW-1:0] rbin, rgray, wq1, wq2, wsync, rlevel;
  logic          empty, ov, fetch;
  logic [W-1:0]  dq;

  assign arst_n = mrst_n & prst_n;

  always_ff @(posedge wclk) if (!mrst_n) fwft_w <= fwft_sel;
  always_ff @(posedge rclk) if (!mrst_n) fwft_r <= fwft_sel;

  // write side
  assign rsync  = g2b(rq2);
  assign wlevel = wbin - rsync;
  assign full   = (wlevel == PW'(DEPTH));
  assign wr_ok  = !wr_n && !full;

  always_ff @(posedge wclk) if (wr_ok) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wclk or negedge arst_n) begin
    if (!arst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_ok) begin
        wbin  <= wbin + PW'(1);
        wgray <= b2g(wbin + PW'(1));
      end
    end
  end

  // read side
  assign wsync  = g2b(wq2);
  assign rlevel = wsync - rbin;
  assign empty  = (rlevel == '0);
  assign fetch  = !empty && (fwft_r ? (!ov || !rd_n) : !rd_n);

  always_ff @(posedge rclk or negedge arst_n) begin
    if (!arst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
      ov    <= 1'b0;
      dq    <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (!retx_n) begin
        rbin  <= '0;
        rgray <= '0;
        ov    <= 1'b0;
      end else if (fetch) begin
        dq    <= mem[rbin[AW-1:0]];
        rbin  <= rbin + PW'(1);
        rgray <= b2g(rbin + PW'(1));
        ov    <= 1'b1;
      end else if (fwft_r && !rd_n) begin
        ov    <= 1'b0;
      end
    end
  end

  // flags and output
  assign full_ir_n  = fwft_w ? full : !full;
  assign empty_or_n = fwft_r ? !ov : !empty;
  assign half_n     = !(wlevel > PW'(DEPTH / 2));
  assign afull_n    = !((PW'(DEPTH) - wlevel) <= af_ofs);
  assign aempty_n   = !(rlevel <= ae_ofs);
  assign dout       = oe_n ? '0 : dq;

endmodule

// File: rtl/xclk_rewind_fifo_chk.sv
module xclk_rewind_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          arst_n,
  input logic          mrst_n,
  input logic          wr_n,
  input logic          retx_n,
  input logic          full,
  input logic          empty,
  input logic          ov,
  input logic          fwft_w,
  input logic          fwft_r,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wlevel
);

  AST_WR_STEP: assert property (@(posedge wclk) disable iff (!arst_n)
    (!wr_n && !full) |=> (wbin == $past(wbin) + PW'(1))); // R1

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!arst_n)
    wr_n |-> (wlevel <= PW'(DEPTH))); // R2

  AST_FULL_HOLD: assert property (@(posedge wclk) disable iff (!arst_n)
    (full && !wr_n) |=> $stable(wbin)); // R2

  AST_EMPTY_HOLD: assert property (@(posedge rclk) disable iff (!arst_n)
    (empty && retx_n) |=> $stable(rbin)); // R3

  AST_FWFT_FILL: assert property (@(posedge rclk) disable iff (!arst_n)
    (fwft_r && !ov && !empty && retx_n) |=> ov); // R5

  AST_RETX_ZERO: assert property (@(posedge rclk) disable iff (!arst_n)
    !retx_n |=> (rbin == '0)); // R11

  AST_MODE_KEEP_W: assert property (@(posedge wclk) disable iff (!mrst_n)
    mrst_n |=> $stable(fwft_w)); // R6

  AST_MODE_KEEP_R: assert property (@(posedge rclk) disable iff (!mrst_n)
    mrst_n |=> $stable(fwft_r)); // R6

endmodule

bind xclk_rewind_fifo xclk_rewind_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .arst_n(arst_n), .mrst_n(mrst_n),
  .wr_n(wr_n), .retx_n(retx_n), .full(full), .empty(empty), .ov(ov),
  .fwft_w(fwft_w), .fwft_r(fwft_r), .wbin(wbin), .rbin(rbin), .wlevel(wlevel)
);

// File: tb/xclk_rewind_fifo_tb_top.sv
`timescale 1ns/1ps
module xclk_rewind_fifo_tb_top;
  localparam int W = 18, DEPTH = 16, PW = 5;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, retx_n = 1'b1, oe_n = 1'b0;
  logic [W-1:0] din = '0;
  logic [PW-1:0] af_ofs = 5'd3, ae_ofs = 5'd2;
  logic [W-1:0] dout;
  logic full_ir_n, empty_or_n, half_n, afull_n, aempty_n;

  int checks = 0, errors = 0;
  bit fw = 1'b0;
  logic [W-1:0] q[$];
  logic [W-1:0] hist[$];

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  xclk_rewind_fifo #(.W(W), .DEPTH(DEPTH)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .wr_n(wr_n), .din(din), .rd_n(rd_n),
    .retx_n(retx_n), .oe_n(oe_n), .af_ofs(af_ofs), .ae_ofs(ae_ofs),
    .dout(dout), .full_ir_n(full_ir_n), .empty_or_n(empty_or_n),
    .half_n(half_n), .afull_n(afull_n), .aempty_n(aempty_n));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_half(int n);  return !(n > DEPTH / 2); endfunction
  function automatic bit exp_af(int n);    return !((DEPTH - n) <= int'(af_ofs)); endfunction
  function automatic bit exp_ae(int n);    return !(n <= int'(ae_ofs)); endfunction
  function automatic bit is_full();        return fw ? (full_ir_n == 1'b1) : (full_ir_n == 1'b0); endfunction

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic do_reset(input bit master, input bit mode);
    wr_n = 1'b1; rd_n = 1'b1; retx_n = 1'b1; fwft_sel = mode;
    if (master) mrst_n = 1'b0; else prst_n = 1'b0;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    while ((($time / 1000) % 14) inside {[5:9]} || (($time / 1000) % 10) inside {[3:7]}) #1;
    mrst_n = 1'b1; prst_n = 1'b1;
    if (master) fw = mode;
    q.delete(); hist.delete();
    repeat (2) @(negedge rclk);
  endtask

  task automatic wr_word(input logic [W-1:0] d, output bit acc);
    @(negedge wclk);
    acc = !is_full();
    wr_n = 1'b0; din = d;
    if (acc) begin q.push_back(d); hist.push_back(d); end
    @(negedge wclk);
    wr_n = 1'b1;
  endtask

  task automatic read_one(input string req);
    logic [W-1:0] e;
    bit have;
    @(negedge rclk);
    if (fw) begin
      have = (empty_or_n == 1'b0);
      if (have) begin
        e = (q.size() > 0) ? q.pop_front() : 'x;
        chk(dout === e, req, dout, e);
      end
      rd_n = 1'b0;
      @(negedge rclk);
      rd_n = 1'b1;
    end else begin
      have = (empty_or_n == 1'b1);
      rd_n = 1'b0;
      @(negedge rclk);
      rd_n = 1'b1;
      if (have) begin
        e = (q.size() > 0) ? q.pop_front() : 'x;
        chk(dout === e, req, dout, e);
      end
    end
  endtask

  task automatic rewind();
    @(negedge rclk);
    retx_n = 1'b0; rd_n = 1'b0;
    @(negedge rclk);
    retx_n = 1'b1; rd_n = 1'b1;
    q = hist;
  endtask

  task automatic drain(input string req);
    settle();
    for (int g = 0; g < 4 * DEPTH && q.size() > 0; g++) read_one(req);
    settle();
    chk(q.size() == 0, req, q.size(), 0);
    chk(empty_or_n == (fw ? 1'b1 : 1'b0), req, empty_or_n, fw);
  endtask

  task automatic rand_phase(input int n);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          @(negedge wclk);
          fwft_sel = 1'($urandom);
          wr_n = ($urandom % 3) == 0;
          din = W'($urandom);
          if (!wr_n && !is_full()) q.push_back(din);
        end
        @(negedge wclk); wr_n = 1'b1;
      end
      begin
        bit pend = 1'b0;
        logic [W-1:0] e;
        for (int i = 0; i < n; i++) begin
          @(negedge rclk);
          if (fw) begin
            if (!empty_or_n) begin
              e = (q.size() > 0) ? q[0] : 'x;
              chk(dout === e, "R1 R5", dout, e);
            end
            rd_n = ($urandom % 2) == 0;
            if (!rd_n && !empty_or_n && q.size() > 0) void'(q.pop_front());
          end else begin
            if (pend) begin
              e = (q.size() > 0) ? q.pop_front() : 'x;
              chk(dout === e, "R1 R4", dout, e);
            end
            rd_n = ($urandom % 2) == 0;
            pend = !rd_n && empty_or_n;
          end
        end
        @(negedge rclk);
        rd_n = 1'b1;
        if (pend) begin
          e = (q.size() > 0) ? q.pop_front() : 'x;
          chk(dout === e, "R1 R4", dout, e);
        end
      end
    join
    fwft_sel = fw;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    bit acc;
    int cnt, k;
    logic [W-1:0] held;
    void'($urandom(32'd2718));

    // standard timing, reset state
    do_reset(1'b1, 1'b0);
    chk(full_ir_n == 1'b1, "R7 full", full_ir_n, 1);
    chk(empty_or_n == 1'b0, "R7 empty", empty_or_n, 0);
    chk(afull_n == 1'b1, "R7 afull", afull_n, 1);
    chk(aempty_n == 1'b0, "R7 aempty", aempty_n, 0);
    chk(half_n == 1'b1, "R7 half", half_n, 1);
    chk(dout == '0, "R7 dout", dout, 0);

    // mode input ignored after reset
    fwft_sel = 1'b1;
    wr_word(18'h01234, acc);
    settle();
    chk(dout == '0, "R6 no fall-through", dout, 0);
    chk(empty_or_n == 1'b1, "R6 std flag", empty_or_n, 1);
    read_one("R4");

    // fill level sweep
    for (int n = 1; n <= DEPTH; n++) begin
      wr_word(W'(n * 37 + 5), acc);
      settle();
      chk(half_n == exp_half(n), "R8", half_n, exp_half(n));
      chk(afull_n == exp_af(n), "R9", afull_n, exp_af(n));
      chk(aempty_n == exp_ae(n), "R10", aempty_n, exp_ae(n));
    end
    chk(full_ir_n == 1'b0, "R2 full", full_ir_n, 0);
    wr_word(18'h3FFFF, acc);
    settle();
    chk(!acc && full_ir_n == 1'b0, "R2 drop", full_ir_n, 0);
    for (int n = 0; n < DEPTH; n++) read_one("R1 R2");
    settle();
    chk(empty_or_n == 1'b0, "R3 empty", empty_or_n, 0);
    held = dout;
    @(negedge rclk); rd_n = 1'b0;
    @(negedge rclk); rd_n = 1'b1;
    @(negedge rclk);
    chk(dout == held, "R3 hold", dout, held);

    // partial reset keeps standard timing; rewind
    do_reset(1'b0, 1'b1);
    chk(empty_or_n == 1'b0, "R6 partial keeps", empty_or_n, 0);
    chk(full_ir_n == 1'b1, "R7 partial", full_ir_n, 1);
    for (int n = 0; n < 5; n++) wr_word(W'(18'h0A000 + n), acc);
    settle();
    for (int n = 0; n < 3; n++) read_one("R4");
    rewind();
    settle();
    for (int n = 0; n < 5; n++) read_one("R11 std");

    // output gating
    held = dout;
    oe_n = 1'b1; #1;
    chk(dout == '0, "R12 gated", dout, 0);
    oe_n = 1'b0; #1;
    chk(dout == held, "R12 restore", dout, held);

    // fall-through timing
    do_reset(1'b1, 1'b1);
    chk(full_ir_n == 1'b0, "R7 ir", full_ir_n, 0);
    chk(empty_or_n == 1'b1, "R7 or", empty_or_n, 1);
    chk(dout == '0, "R7 dout", dout, 0);
    fwft_sel = 1'b0;
    wr_word(18'h0B0B0, acc);
    k = 0;
    while (empty_or_n && k < 8) begin @(negedge rclk); k++; end
    chk(k <= 5 && !empty_or_n, "R5 latency", k, 5);
    chk(dout == 18'h0B0B0, "R5 head", dout, 18'h0B0B0);
    read_one("R5");
    settle();
    chk(empty_or_n == 1'b1, "R5 drained", empty_or_n, 1);

    // fall-through rewind
    do_reset(1'b0, 1'b0);
    chk(empty_or_n == 1'b1, "R6 partial keeps fwft", empty_or_n, 1);
    for (int n = 0; n < 4; n++) wr_word(W'(18'h0C000 + n), acc);
    settle();
    read_one("R5"); read_one("R5");
    rewind();
    settle();
    chk(dout == 18'h0C000, "R11 fwft head", dout, 18'h0C000);
    for (int n = 0; n < 4; n++) read_one("R11 fwft");

    // fall-through capacity
    do_reset(1'b0, 1'b0);
    wr_word(18'h0D000, acc);
    settle();
    cnt = 1;
    for (int n = 1; n < DEPTH + 3; n++) begin
      wr_word(W'(18'h0D000 + n), acc);
      if (acc) cnt++;
    end
    settle();
    chk(cnt == DEPTH + 1, "R2 fwft capacity", cnt, DEPTH + 1);
    chk(full_ir_n == 1'b1, "R2 fwft full", full_ir_n, 1);
    drain("R1 R5");

    // random traffic, both timings
    rand_phase(600);
    drain("R1 R5");
    do_reset(1'b1, 1'b0);
    rand_phase(600);
    drain("R1 R4");

    finish_run();
  end
endmodule